// File: doc/BRIEF.md
# Discriminator Threshold Serial Loader

This block sends configuration to a 32-channel front-end discriminator board over a three-wire serial link: a serial clock, a data line and a load strobe. The board carries four 8-channel discriminator chips. Each chip has a single 10-bit threshold DAC code, and one code step moves that chip's threshold by 4 mV. The same link can also tell the board to fire its on-board test pulse.

A host presents one request at a time on a valid/ready handshake. A request is either a threshold write for one chip address with a 10-bit code, or a test-pulse fire command. The block packs the request into a 13-bit frame and shifts it out MSB first, changing data only on falling serial-clock edges. It then raises the load strobe for one system cycle, pulses `done`, and returns to idle. The serial clock period is `CLK_DIV` system cycles: half the period low, half high.

Top module: `thr_serial_loader`

## Requirements
- R1: While reset is asserted and right after it, `ser_clk`, `ser_data`, `ser_load`, `busy` and `done` are low and `req_ready` is high.
- R2: The frame is 13 bits, sent first to last as: command type bit (0 = threshold, 1 = fire), 2-bit chip address MSB first, then the 10-bit code MSB first.
- R3: `ser_clk` is low outside a frame. Each frame bit is held for CLK_DIV/2 cycles with `ser_clk` low and then CLK_DIV/2 cycles with it high. `ser_data` changes only when `ser_clk` falls, and the first bit appears in the cycle after acceptance.
- R4: In the cycle after the last falling edge of `ser_clk`, `ser_load` is high for exactly one cycle, with `ser_clk` and `ser_data` low.
- R5: `busy` is high from the cycle after acceptance through the strobe cycle. `done` is high for exactly the one cycle that follows the strobe.
- R6: `req_ready` is high only when idle. It is low from the cycle after acceptance until the cycle after `done`. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high.
- R7: `req_valid` asserted while `req_ready` is low is ignored, and the frame in progress continues unchanged.
- R8: A fire command sends type bit 1 and the given chip address, with all ten code bits sent as 0 whatever `req_code` holds.
- R9: A threshold command sends type bit 0, the given address (0 to 3) and `req_code` unchanged, including the codes 0 and 1023.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_fire | input | 1 | 1 = fire test pulse, 0 = threshold write |
| req_chip | input | 2 | Target chip address |
| req_code | input | 10 | Threshold DAC code |
| busy | output | 1 | Frame or strobe in progress |
| done | output | 1 | One-cycle completion pulse |
| ser_clk | output | 1 | Serial clock to the board |
| ser_data | output | 1 | Serial data to the board |
| ser_load | output | 1 | Load strobe to the board |

## Verification
A wrong bit index or an extra shift shows up on `ser_data` at the first falling edge after the error, within CLK_DIV cycles, and a miscounted frame moves `ser_load` and `done` by at least one bit period. A phase-counter error changes the low or high time of `ser_clk` in the same half period. A state machine that accepts during busy would restart the frame, and `ser_data` would disagree within one bit. The bench compares every output port with a queue-based model on every cycle, so each of these faults is reported in the cycle it first becomes visible.

// File: rtl/thr_serial_pkg.sv
package thr_serial_pkg;

    typedef enum logic [1:0] {
        LD_IDLE   = 2'd0,
        LD_SHIFT  = 2'd1,
        LD_STROBE = 2'd2,
        LD_DONE   = 2'd3
    } ld_state_e;

    localparam logic CMD_THRESH = 1'b0;
    localparam logic CMD_FIRE   = 1'b1;

endpackage

// File: rtl/thr_frame_build.sv
module thr_frame_build #(
    parameter int ADDR_W  = 2,
    parameter int CODE_W  = 10,
    parameter int FRAME_W = 1 + ADDR_W + CODE_W
) (
    input  logic               fire,
    input  logic [ADDR_W-1:0]  chip,
    input  logic [CODE_W-1:0]  code,
    output logic [FRAME_W-1:0] frame
);
    import thr_serial_pkg::*;

    logic [CODE_W-1:0] code_f;

    // fire commands carry an all-zero code field
    for (genvar i = 0; i < CODE_W; i++) begin : g_code_mask
        assign code_f[i] = code[i] & (fire == CMD_THRESH);
    end

    always_comb begin
        frame = {fire, chip, code_f};
    end

endmodule

// File: rtl/thr_sclk_timer.sv
module thr_sclk_timer #(
    parameter int CLK_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic sclk,
    output logic fall
);
    localparam int HALF  = (CLK_DIV / 2 < 1) ? 1 : CLK_DIV / 2;
    localparam int CNT_W = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HALF - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             sclk;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (!run) begin
            tmr_d.cnt  = '0;
            tmr_d.sclk = 1'b0;
        end else if (tmr_q.cnt == CNT_LAST) begin
            tmr_d.cnt  = '0;
            tmr_d.sclk = ~tmr_q.sclk;
        end else begin
            tmr_d.cnt  = tmr_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign sclk = tmr_q.sclk;
    assign fall = run && tmr_q.sclk && (tmr_q.cnt == CNT_LAST);

    // R3: serial clock parks low once the shifter stops running
    p_park_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !sclk);

endmodule

// File: rtl/thr_serial_loader.sv
module thr_serial_loader #(
    parameter int CHIPS   = 4,
    parameter int CODE_W  = 10,
    parameter int CLK_DIV = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_valid,
    output logic                       req_ready,
    input  logic                       req_fire,
    input  logic [$clog2(CHIPS)-1:0]   req_chip,
    input  logic [CODE_W-1:0]          req_code,
    output logic                       busy,
    output logic                       done,
    output logic                       ser_clk,
    output logic                       ser_data,
    output logic                       ser_load
);
    import thr_serial_pkg::*;

    localparam int ADDR_W  = $clog2(CHIPS);
    localparam int FRAME_W = 1 + ADDR_W + CODE_W;
    localparam int IDX_W   = $clog2(FRAME_W);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(FRAME_W - 1);

    typedef struct packed {
        ld_state_e          st;
        logic [FRAME_W-1:0] sreg;
        logic [IDX_W-1:0]   idx;
    } ld_t;

    ld_t ld_d, ld_q;

    logic [FRAME_W-1:0] frame;
    logic               run;
    logic               fall;

    thr_frame_build #(
        .ADDR_W (ADDR_W),
        .CODE_W (CODE_W),
        .FRAME_W(FRAME_W)
    ) i_frame (
        .fire (req_fire),
        .chip (req_chip),
        .code (req_code),
        .frame(frame)
    );

    assign run = (ld_q.st == LD_SHIFT);

    thr_sclk_timer #(
        .CLK_DIV(CLK_DIV)
    ) i_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (run),
        .sclk (ser_clk),
        .fall (fall)
    );

    always_comb begin
        ld_d = ld_q;
        unique case (ld_q.st)
            LD_IDLE: begin
                if (req_valid) begin
                    ld_d.st   = LD_SHIFT;
                    ld_d.sreg = frame;
                    ld_d.idx  = '0;
                end
            end
            LD_SHIFT: begin
                if (fall) begin
                    if (ld_q.idx == IDX_LAST) begin
                        ld_d.st   = LD_STROBE;
                        ld_d.sreg = '0;
                    end else begin
                        ld_d.idx  = ld_q.idx + 1'b1;
                        ld_d.sreg = {ld_q.sreg[FRAME_W-2:0], 1'b0};
                    end
                end
            end
            LD_STROBE: ld_d.st = LD_DONE;
            LD_DONE:   ld_d.st = LD_IDLE;
            default:   ld_d.st = LD_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ld_q <= '{st: LD_IDLE, sreg: '0, idx: '0};
        end else begin
            ld_q <= ld_d;
        end
    end

    assign ser_data  = ld_q.sreg[FRAME_W-1];
    assign ser_load  = (ld_q.st == LD_STROBE);
    assign busy      = (ld_q.st == LD_SHIFT) || (ld_q.st == LD_STROBE);
    assign done      = (ld_q.st == LD_DONE);
    assign req_ready = (ld_q.st == LD_IDLE);

    // R4: strobe lasts a single cycle
    p_load_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ser_load |=> !ser_load);

    // R4: strobe happens with clock and data low
    p_load_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ser_load |-> (!ser_clk && !ser_data));

    // R5: completion pulse directly follows the strobe
    p_done_after_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ser_load |=> (done && !busy));

    // R6: ready only while nothing is in flight
    p_ready_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!busy && !done));

    // R3: data steady across a high serial-clock phase
    p_data_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_clk && $past(ser_clk)) |-> $stable(ser_data));

    // R3: serial clock low outside a frame
    p_clk_low_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !ser_clk);

    // R7: a request while not ready does not disturb the running frame
    p_refuse_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !ser_clk && !$past(ser_clk) && $past(busy)) |-> $stable(ser_data));

endmodule

// File: tb/test_thr_serial_loader.sv
module test_thr_serial_loader;
    localparam int CLK_PERIOD = 10;
    localparam int CHIPS      = 4;
    localparam int CODE_W     = 10;
    localparam int CLK_DIV    = 4;
    localparam int HALF       = CLK_DIV / 2;
    localparam int FRAME_W    = 1 + 2 + CODE_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic              req_fire = 1'b0;
    logic [1:0]        req_chip = '0;
    logic [CODE_W-1:0] req_code = '0;
    logic              busy, done, ser_clk, ser_data, ser_load;

    always #(CLK_PERIOD / 2) clk = ~clk;

    thr_serial_loader #(
        .CHIPS  (CHIPS),
        .CODE_W (CODE_W),
        .CLK_DIV(CLK_DIV)
    ) i_thr_serial_loader (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_valid(req_valid),
        .req_ready(req_ready),
        .req_fire (req_fire),
        .req_chip (req_chip),
        .req_code (req_code),
        .busy     (busy),
        .done     (done),
        .ser_clk  (ser_clk),
        .ser_data (ser_data),
        .ser_load (ser_load)
    );

    // expected port values for one cycle: sclk, data, load, busy, done, ready
    typedef struct packed {
        logic sclk;
        logic data;
        logic load;
        logic busy;
        logic done;
        logic ready;
    } exp_t;

    localparam exp_t IDLE_EXP = 6'b000001;

    exp_t  q[$];
    exp_t  cur = IDLE_EXP;
    int    checks = 0;
    int    errors = 0;
    int    cycles = 0;
    bit    finished = 1'b0;
    string data_tag = "R2";

    task automatic chk(input bit ok, input string tag, input logic act, input logic expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, expv, $time);
        end
    endtask

    function automatic void enqueue(input logic fire, input logic [1:0] chip,
                                    input logic [CODE_W-1:0] code);
        logic [FRAME_W-1:0] f;
        f = {fire, chip, (fire ? {CODE_W{1'b0}} : code)};
        for (int b = FRAME_W - 1; b >= 0; b--) begin
            for (int h = 0; h < HALF; h++) q.push_back({1'b0, f[b], 1'b0, 1'b1, 1'b0, 1'b0});
            for (int h = 0; h < HALF; h++) q.push_back({1'b1, f[b], 1'b0, 1'b1, 1'b0, 1'b0});
        end
        q.push_back(6'b001100);
        q.push_back(6'b000010);
    endfunction

    // reference model advanced on each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            q.delete();
            cur = IDLE_EXP;
        end else begin
            if (cur.ready && req_valid) enqueue(req_fire, req_chip, req_code);
            if (q.size() > 0) cur = q.pop_front();
            else cur = IDLE_EXP;
        end
    end

    // compare every cycle away from the rising edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk(ser_clk === cur.sclk,   "R3 ser_clk",   ser_clk,   cur.sclk);
            chk(ser_data === cur.data,  data_tag,       ser_data,  cur.data);
            chk(ser_load === cur.load,  "R4 ser_load",  ser_load,  cur.load);
            chk(busy === cur.busy,      "R5 busy",      busy,      cur.busy);
            chk(done === cur.done,      "R5 done",      done,      cur.done);
            chk(req_ready === cur.ready, "R6 req_ready", req_ready, cur.ready);
        end
    end

    task automatic summary();
        finished = 1'b1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000 && !finished) begin
            errors++;
            $display("FAIL watchdog: actual running expected idle after %0d cycles", cycles);
            summary();
        end
    end

    task automatic send(input logic fire, input logic [1:0] chip, input logic [CODE_W-1:0] code,
                        input string tag);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        data_tag  = tag;
        req_fire  = fire;
        req_chip  = chip;
        req_code  = code;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    initial begin
        // R1: outputs quiet during reset
        repeat (3) @(negedge clk);
        chk(ser_clk === 1'b0,   "R1 ser_clk in reset",  ser_clk,   1'b0);
        chk(ser_data === 1'b0,  "R1 ser_data in reset", ser_data,  1'b0);
        chk(ser_load === 1'b0,  "R1 ser_load in reset", ser_load,  1'b0);
        chk(busy === 1'b0,      "R1 busy in reset",     busy,      1'b0);
        chk(done === 1'b0,      "R1 done in reset",     done,      1'b0);
        chk(req_ready === 1'b1, "R1 ready in reset",    req_ready, 1'b1);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R9: every chip address, extreme and alternating codes
        send(1'b0, 2'd0, 10'h3FF, "R2 R9 data");
        send(1'b0, 2'd1, 10'h000, "R2 R9 data");
        send(1'b0, 2'd2, 10'h155, "R2 R9 data");
        send(1'b0, 2'd3, 10'h2AA, "R2 R9 data");

        // R8: fire command with a nonzero code on the bus
        send(1'b1, 2'd2, 10'h3FF, "R2 R8 data");
        send(1'b1, 2'd1, 10'h081, "R2 R8 data");

        // R7: requests during a frame are refused
        send(1'b0, 2'd1, 10'h123, "R2 R7 data");
        req_fire  = 1'b1;
        req_chip  = 2'd3;
        req_code  = 10'h3C3;
        req_valid = 1'b1;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            chk(req_ready === 1'b0, "R7 ready while busy", req_ready, 1'b0);
        end
        req_valid = 1'b0;

        // back-to-back after completion
        send(1'b0, 2'd3, 10'h001, "R2 R9 data");
        send(1'b0, 2'd0, 10'h200, "R2 R9 data");

        @(negedge clk);
        while (!req_ready) @(negedge clk);
        repeat (5) @(negedge clk);
        summary();
    end

endmodule